// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer

This block is a 16-bit down-counter paired with two 16-bit holding registers, A and B. A 3-bit mode field gives the two registers and the first external pin a different job in each operating mode. The first mode is a free-standing pulse-width generator. In this mode the counter reloads from A and B in turn, so A sets the high time of the output and B sets the low time. The second mode is an event counter. Here the first pin becomes the count clock, and the output driver is turned off. The third mode is input capture. The counter runs freely, and edges on either pin copy the running count into A or B.

Each mode raises two pending flags, one per interrupt source. Software clears a flag by pulsing its clear input. Both pins are brought into the clock domain through a two-flop synchroniser before edge detection. A run input pauses or resumes counting and leaves the count as it is. Reset does not initialise the counter or the two holding registers. Software must write them before it relies on their contents.

Top module: `tmr16_mm`

## Requirements
- R1: While reset is asserted (rst_n low), pend_a_o, pend_b_o and pwm_o are 0.
- R2: mode_i[2:1] selects the mode: 00 pulse-width, 01 event counter, 10 capture, 11 hold. In hold mode the count never changes except by a software write, and no flag is set by any pin edge. mode_i[0] selects the active edge in event and capture modes: 0 means rising, 1 means falling.
- R3: In pulse-width mode with run high, the count decrements every cycle. In a cycle where the count is 0, pwm_o toggles instead. On a rise of pwm_o the count reloads from A and pend_a_o is set. On a fall of pwm_o the count reloads from B and pend_b_o is set. The high phase therefore lasts A+1 cycles and the low phase lasts B+1 cycles.
- R4: pwm_oe_o is 1 in pulse-width mode and 0 in every other mode.
- R5: In event mode with run high, the count decrements once per active edge on pin_a_i. An active edge that arrives while the count is 0 reloads the count from A and sets pend_a_o. An active edge on pin_b_i sets pend_b_o.
- R6: In capture mode with run high, the count decrements every cycle and wraps from 0 to 16'hFFFF. Each wrap sets pend_b_o.
- R7: In capture mode with run high, an active edge on pin_a_i copies the count held in that cycle into A and sets pend_a_o. An active edge on pin_b_i copies the count into B and sets pend_b_o.
- R8: A pin level that changes before rising clock edge k takes effect at rising edge k+2. The bench observes this after edge k+2 and not before it.
- R9: With run low, the count holds and pin edges have no effect. No capture takes place and no flag is set. Flag clears still work.
- R10: A count write in a cycle overrides counting in that cycle. A write to A or B overrides a capture into the same register. A flag set in the same cycle as its clear leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | [2:1] mode, [0] edge polarity |
| run_i | input | 1 | Counting enable |
| cnt_wr_i | input | 1 | Write strobe for the count |
| cnt_wdata_i | input | 16 | Count write data |
| ra_wr_i | input | 1 | Write strobe for register A |
| ra_wdata_i | input | 16 | Register A write data |
| rb_wr_i | input | 1 | Write strobe for register B |
| rb_wdata_i | input | 16 | Register B write data |
| pin_a_i | input | 1 | First timer pin (count clock or capture input) |
| pin_b_i | input | 1 | Second timer pin (capture input) |
| clr_a_i | input | 1 | Clear pulse for pending flag A |
| clr_b_i | input | 1 | Clear pulse for pending flag B |
| pwm_o | output | 1 | Pulse-width output level |
| pwm_oe_o | output | 1 | Output enable for the first pin |
| count_o | output | 16 | Current count |
| ra_o | output | 16 | Register A |
| rb_o | output | 16 | Register B |
| pend_a_o | output | 1 | Pending flag A |
| pend_b_o | output | 1 | Pending flag B |

## Verification
The corner that is hardest to reach from the ports is an event that lands in the same cycle as a competing action. Examples are an edge that reaches the count exactly at 0 in event mode, a capture at the moment of a software write, and a flag set while its clear is held. Small random values for the count and the holding registers keep underflows frequent in every mode. Random pin toggles and occasional writes and clears then produce such coincidences often. Directed sequences fix the synchroniser latency, the wrap to 16'hFFFF, the effect of run low, and the set-over-clear case at exact cycles.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int TMR_W = 16;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MD_PWM  = 2'b00,
    MD_EVT  = 2'b01,
    MD_CAP  = 2'b10,
    MD_HOLD = 2'b11
  } tmr_mode_e;

  function automatic logic [TMR_W-1:0] count_down(input logic [TMR_W-1:0] c);
    return c - {{(TMR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic pick_edge(input logic fall_sel, input logic rise, input logic fall);
    return fall_sel ? fall : rise;
  endfunction
endpackage

// File: rtl/tmr16_pin_sync.sv
module tmr16_pin_sync #(
  parameter int PINS = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pin_i,
  output logic [PINS-1:0] rise_o,
  output logic [PINS-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[DEPTH-2:0], pin_i[p]};
    end
    assign rise_o[p] = sh[STAGES-1] & ~sh[STAGES];
    assign fall_o[p] = ~sh[STAGES-1] & sh[STAGES];
  end
endmodule

// File: rtl/tmr16_count_unit.sv
module tmr16_count_unit
  import tmr16_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    md,
  input  logic         run_i,
  input  logic         edge_a,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic [W-1:0] ra,
  input  logic [W-1:0] rb,
  output logic [W-1:0] count_o,
  output logic         pwm_o,
  output logic         uf_evt
);
  logic         tick;
  logic         at_zero;
  logic [W-1:0] reload_val;

  always_comb begin
    case (md)
      MD_PWM:  tick = run_i;
      MD_CAP:  tick = run_i;
      MD_EVT:  tick = run_i & edge_a;
      default: tick = 1'b0;
    endcase
  end

  assign at_zero    = (count_o == '0);
  assign uf_evt     = tick & at_zero & ~cnt_wr_i;
  assign reload_val = (md == MD_PWM && pwm_o) ? rb : ra;

  always_ff @(posedge clk) begin
    if (cnt_wr_i) begin
      count_o <= cnt_wdata_i;
    end else if (tick) begin
      if (at_zero && md != MD_CAP) count_o <= reload_val;
      else                         count_o <= count_down(count_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pwm_o <= 1'b0;
    else if (uf_evt && md == MD_PWM)   pwm_o <= ~pwm_o;
  end
endmodule

// File: rtl/tmr16_hold_regs.sv
module tmr16_hold_regs
  import tmr16_pkg::*;
#(
  parameter int W = TMR_W
) (
  input  logic         clk,
  input  logic         ra_wr_i,
  input  logic [W-1:0] ra_wdata_i,
  input  logic         rb_wr_i,
  input  logic [W-1:0] rb_wdata_i,
  input  logic         cap_a,
  input  logic         cap_b,
  input  logic [W-1:0] count,
  output logic [W-1:0] ra_o,
  output logic [W-1:0] rb_o
);
  always_ff @(posedge clk) begin
    if (ra_wr_i)    ra_o <= ra_wdata_i;
    else if (cap_a) ra_o <= count;
    if (rb_wr_i)    rb_o <= rb_wdata_i;
    else if (cap_b) rb_o <= count;
  end
endmodule

// File: rtl/tmr16_flags.sv
module tmr16_flags
  import tmr16_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e md,
  input  logic      act_a,
  input  logic      act_b,
  input  logic      uf_evt,
  input  logic      pwm_lvl,
  input  logic      clr_a_i,
  input  logic      clr_b_i,
  output logic      set_a,
  output logic      set_b,
  output logic      pend_a_o,
  output logic      pend_b_o
);
  always_comb begin
    case (md)
      MD_PWM: begin set_a = uf_evt & ~pwm_lvl; set_b = uf_evt & pwm_lvl; end
      MD_EVT: begin set_a = uf_evt;            set_b = act_b;            end
      MD_CAP: begin set_a = act_a;             set_b = act_b | uf_evt;   end
      default: begin set_a = 1'b0;             set_b = 1'b0;             end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_a_o <= 1'b0;
      pend_b_o <= 1'b0;
    end else begin
      if (set_a)        pend_a_o <= 1'b1;
      else if (clr_a_i) pend_a_o <= 1'b0;
      if (set_b)        pend_b_o <= 1'b1;
      else if (clr_b_i) pend_b_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr16_mm.sv
module tmr16_mm
  import tmr16_pkg::*;
#(
  parameter int W = TMR_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode_i,
  input  logic         run_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         ra_wr_i,
  input  logic [W-1:0] ra_wdata_i,
  input  logic         rb_wr_i,
  input  logic [W-1:0] rb_wdata_i,
  input  logic         pin_a_i,
  input  logic         pin_b_i,
  input  logic         clr_a_i,
  input  logic         clr_b_i,
  output logic         pwm_o,
  output logic         pwm_oe_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] ra_o,
  output logic [W-1:0] rb_o,
  output logic         pend_a_o,
  output logic         pend_b_o
);
  tmr_mode_e  md;
  logic [1:0] pin_rise, pin_fall;
  logic       edge_a_sel, edge_b_sel;
  logic       act_a, act_b;
  logic       uf_evt;
  logic       set_a, set_b;

  assign md         = tmr_mode_e'(mode_i[2:1]);
  assign edge_a_sel = pick_edge(mode_i[0], pin_rise[0], pin_fall[0]);
  assign edge_b_sel = pick_edge(mode_i[0], pin_rise[1], pin_fall[1]);
  assign act_a      = run_i & edge_a_sel;
  assign act_b      = run_i & edge_b_sel;
  assign pwm_oe_o   = (md == MD_PWM);

  tmr16_pin_sync #(.PINS(2), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i({pin_b_i, pin_a_i}),
    .rise_o(pin_rise), .fall_o(pin_fall)
  );

  tmr16_count_unit #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .md(md), .run_i(run_i), .edge_a(edge_a_sel),
    .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i), .ra(ra_o), .rb(rb_o),
    .count_o(count_o), .pwm_o(pwm_o), .uf_evt(uf_evt)
  );

  tmr16_hold_regs #(.W(W)) u_regs (
    .clk(clk), .ra_wr_i(ra_wr_i), .ra_wdata_i(ra_wdata_i),
    .rb_wr_i(rb_wr_i), .rb_wdata_i(rb_wdata_i),
    .cap_a(md == MD_CAP && act_a), .cap_b(md == MD_CAP && act_b),
    .count(count_o), .ra_o(ra_o), .rb_o(rb_o)
  );

  tmr16_flags u_flags (
    .clk(clk), .rst_n(rst_n), .md(md), .act_a(act_a), .act_b(act_b),
    .uf_evt(uf_evt), .pwm_lvl(pwm_o), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
    .set_a(set_a), .set_b(set_b), .pend_a_o(pend_a_o), .pend_b_o(pend_b_o)
  );
endmodule

// File: rtl/tmr16_mm_chk.sv
module tmr16_mm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   mode_i,
  input logic         run_i,
  input logic         cnt_wr_i,
  input logic         ra_wr_i,
  input logic         rb_wr_i,
  input logic         edge_a_sel,
  input logic         edge_b_sel,
  input logic         uf_evt,
  input logic         pwm_o,
  input logic [W-1:0] count_o,
  input logic [W-1:0] ra_o,
  input logic [W-1:0] rb_o,
  input logic         pend_a_o,
  input logic         pend_b_o
);
  assert_pwm_toggle_on_uf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o != $past(pwm_o)) |-> $past(uf_evt && mode_i[2:1] == 2'b00));

  assert_evt_idle_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b01 && run_i && !edge_a_sel && !cnt_wr_i) |=> $stable(count_o));

  assert_cap_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b10 && run_i && !cnt_wr_i) |=> (count_o == $past(count_o) - 16'd1));

  assert_cap_load_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b10 && run_i && edge_a_sel && !ra_wr_i) |=> (ra_o == $past(count_o)));

  assert_cap_load_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b10 && run_i && edge_b_sel && !rb_wr_i) |=> (rb_o == $past(count_o)));

  assert_cap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b10 && run_i && edge_a_sel) |=> pend_a_o);

  assert_stopped_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cnt_wr_i) |=> $stable(count_o));

  assert_stopped_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !pend_b_o) |=> !pend_b_o);

  assert_hold_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2:1] == 2'b11 && !cnt_wr_i) |=> $stable(count_o));
endmodule

bind tmr16_mm tmr16_mm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .run_i(run_i),
  .cnt_wr_i(cnt_wr_i), .ra_wr_i(ra_wr_i), .rb_wr_i(rb_wr_i),
  .edge_a_sel(edge_a_sel), .edge_b_sel(edge_b_sel), .uf_evt(uf_evt),
  .pwm_o(pwm_o), .count_o(count_o), .ra_o(ra_o), .rb_o(rb_o),
  .pend_a_o(pend_a_o), .pend_b_o(pend_b_o)
);

// File: tb/test_tmr16_mm.sv
`timescale 1ns/1ps
module test_tmr16_mm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_i = 3'b000;
  logic        run_i = 1'b0;
  logic        cnt_wr_i = 1'b0, ra_wr_i = 1'b0, rb_wr_i = 1'b0;
  logic [15:0] cnt_wdata_i = '0, ra_wdata_i = '0, rb_wdata_i = '0;
  logic        pin_a_i = 1'b0, pin_b_i = 1'b0;
  logic        clr_a_i = 1'b0, clr_b_i = 1'b0;
  logic        pwm_o, pwm_oe_o, pend_a_o, pend_b_o;
  logic [15:0] count_o, ra_o, rb_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;
  bit vals_ok = 0;

  always #2.5 clk = ~clk;

  tmr16_mm i_tmr16_mm (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference built from the requirements
  logic [15:0] m_cnt, m_ra, m_rb;
  logic        m_pwm, m_pa, m_pb;
  logic [2:0]  m_sa, m_sb;

  function automatic logic sel_edge(input logic pol, input logic [2:0] s);
    return pol ? (~s[1] & s[2]) : (s[1] & ~s[2]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic ea, eb, tk, uf, sa, sb;
    logic [1:0] md;
    if (!rst_n) begin
      m_pwm <= 0; m_pa <= 0; m_pb <= 0; m_sa <= 0; m_sb <= 0;
    end else begin
      md = mode_i[2:1];
      ea = run_i & sel_edge(mode_i[0], m_sa);
      eb = run_i & sel_edge(mode_i[0], m_sb);
      tk = run_i & ((md == 2'b00) | (md == 2'b10) | ((md == 2'b01) & ea));
      uf = tk & (m_cnt == 16'd0) & ~cnt_wr_i;
      if (cnt_wr_i) m_cnt <= cnt_wdata_i;
      else if (tk) begin
        if (m_cnt == 0 && md == 2'b00) m_cnt <= m_pwm ? m_rb : m_ra;
        else if (m_cnt == 0 && md == 2'b01) m_cnt <= m_ra;
        else m_cnt <= m_cnt - 16'd1;
      end
      if (uf && md == 2'b00) m_pwm <= ~m_pwm;
      sa = 0; sb = 0;
      case (md)
        2'b00: begin sa = uf & ~m_pwm; sb = uf & m_pwm; end
        2'b01: begin sa = uf; sb = eb; end
        2'b10: begin sa = ea; sb = eb | uf; end
        default: ;
      endcase
      if (sa) m_pa <= 1; else if (clr_a_i) m_pa <= 0;
      if (sb) m_pb <= 1; else if (clr_b_i) m_pb <= 0;
      if (ra_wr_i) m_ra <= ra_wdata_i; else if (md == 2'b10 && ea) m_ra <= m_cnt;
      if (rb_wr_i) m_rb <= rb_wdata_i; else if (md == 2'b10 && eb) m_rb <= m_cnt;
      m_sa <= {m_sa[1:0], pin_a_i};
      m_sb <= {m_sb[1:0], pin_b_i};
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on && !done) begin
      string t;
      case (mode_i[2:1])
        2'b00: t = "R3"; 2'b01: t = "R5"; 2'b10: t = "R7"; default: t = "R2";
      endcase
      chk("R4", {15'd0, pwm_oe_o}, {15'd0, mode_i[2:1] == 2'b00});
      chk(t, {15'd0, pwm_o}, {15'd0, m_pwm});
      chk(t, {15'd0, pend_a_o}, {15'd0, m_pa});
      chk(t, {15'd0, pend_b_o}, {15'd0, m_pb});
      if (vals_ok) begin
        chk(t, count_o, m_cnt);
        chk(t, ra_o, m_ra);
        chk(t, rb_o, m_rb);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_all(input logic [15:0] c, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    cnt_wr_i = 1; ra_wr_i = 1; rb_wr_i = 1;
    cnt_wdata_i = c; ra_wdata_i = a; rb_wdata_i = b;
    @(negedge clk);
    cnt_wr_i = 0; ra_wr_i = 0; rb_wr_i = 0;
  endtask

  task automatic clear_flags();
    @(negedge clk); clr_a_i = 1; clr_b_i = 1;
    @(negedge clk); clr_a_i = 0; clr_b_i = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    nclk(3);
    chk("R1", {15'd0, pend_a_o}, 16'd0);
    chk("R1", {15'd0, pend_b_o}, 16'd0);
    chk("R1", {15'd0, pwm_o}, 16'd0);
    rst_n = 1;
    cmp_on = 1;
    wr_all(16'd5, 16'd3, 16'd2);
    vals_ok = 1;

    // Random phase over every mode and polarity
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        mode_i = 3'(m);
        run_i = ($urandom % 16) != 0;
        if ($urandom % 3 == 0) pin_a_i = ~pin_a_i;
        if ($urandom % 5 == 0) pin_b_i = ~pin_b_i;
        cnt_wr_i = ($urandom % 150) == 0;
        cnt_wdata_i = 16'($urandom % 12);
        ra_wr_i = ($urandom % 200) == 0;
        ra_wdata_i = 16'($urandom % 10);
        rb_wr_i = ($urandom % 200) == 0;
        rb_wdata_i = 16'($urandom % 10);
        clr_a_i = ($urandom % 8) == 0;
        clr_b_i = ($urandom % 8) == 0;
      end
    end
    @(negedge clk);
    cnt_wr_i = 0; ra_wr_i = 0; rb_wr_i = 0; clr_a_i = 0; clr_b_i = 0;
    pin_a_i = 0; pin_b_i = 0; run_i = 0;

    // R3: phase lengths A+1 high and B+1 low
    mode_i = 3'b000;
    wr_all(16'd0, 16'd3, 16'd5);
    run_i = 1;
    begin
      int hi, lo, guard;
      guard = 0;
      while (pwm_o !== 1'b0 && guard < 40) begin @(negedge clk); guard++; end
      while (pwm_o !== 1'b1 && guard < 80) begin @(negedge clk); guard++; end
      hi = 0;
      while (pwm_o === 1'b1 && hi < 40) begin @(negedge clk); hi++; end
      lo = 0;
      while (pwm_o === 1'b0 && lo < 40) begin @(negedge clk); lo++; end
      chk("R3 high", 16'(hi), 16'd4);
      chk("R3 low", 16'(lo), 16'd6);
    end

    // R5: event counting, reload at zero
    run_i = 0; mode_i = 3'b010;
    wr_all(16'd2, 16'd7, 16'd1);
    clear_flags();
    run_i = 1;
    for (int e = 0; e < 3; e++) begin
      @(negedge clk); pin_a_i = 1; nclk(4);
      pin_a_i = 0; nclk(4);
    end
    chk("R5 reload", count_o, 16'd7);
    chk("R5 flag", {15'd0, pend_a_o}, 16'd1);

    // R8 and R7: latency of the capture path
    mode_i = 3'b100;
    nclk(4);
    clear_flags();
    @(negedge clk); pin_a_i = 1;
    @(negedge clk);
    chk("R8 early", {15'd0, pend_a_o}, 16'd0);
    @(negedge clk);
    chk("R8 early", {15'd0, pend_a_o}, 16'd0);
    begin
      logic [15:0] cap_exp;
      cap_exp = count_o;
      @(negedge clk);
      chk("R8 arrive", {15'd0, pend_a_o}, 16'd1);
      chk("R7 capture", ra_o, cap_exp);
    end

    // R6: wrap from zero
    @(negedge clk); cnt_wr_i = 1; cnt_wdata_i = 16'd0; clr_b_i = 1;
    @(negedge clk); cnt_wr_i = 0; clr_b_i = 0;
    chk("R10 write", count_o, 16'd0);
    @(negedge clk);
    chk("R6 wrap", count_o, 16'hFFFF);
    chk("R6 flag", {15'd0, pend_b_o}, 16'd1);

    // R10: set wins over a held clear (falling polarity)
    mode_i = 3'b101;
    clr_a_i = 1; nclk(2);
    pin_a_i = 0;
    nclk(2);
    @(negedge clk);
    chk("R10 set over clear", {15'd0, pend_a_o}, 16'd1);
    @(negedge clk);
    chk("R10 clear after", {15'd0, pend_a_o}, 16'd0);
    clr_a_i = 0;

    // R9: stopped timer ignores pins, clear still works
    run_i = 0; mode_i = 3'b100;
    @(negedge clk); clr_a_i = 1; clr_b_i = 1;
    @(negedge clk); clr_a_i = 0; clr_b_i = 0;
    chk("R9 clear", {15'd0, pend_b_o}, 16'd0);
    begin
      logic [15:0] c0, a0;
      c0 = count_o; a0 = ra_o;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); pin_a_i = ~pin_a_i; pin_b_i = ~pin_b_i; nclk(1);
      end
      nclk(4);
      chk("R9 count", count_o, c0);
      chk("R9 ra", ra_o, a0);
      chk("R9 flag", {15'd0, pend_a_o}, 16'd0);
    end

    // R2: hold mode
    mode_i = 3'b110; run_i = 1;
    begin
      logic [15:0] c1;
      c1 = count_o;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); pin_a_i = ~pin_a_i; nclk(3);
      end
      chk("R2 hold", count_o, c1);
    end

    nclk(2);
    finish_run();
  end
endmodule